// File: doc/BRIEF.md
# Cross-Domain Periodic Interrupt Timer

The block raises a periodic interrupt whose rate is set by a period value held in a register on a fast bus clock. The counter that produces the events runs on a separate, slower timer clock. A nonzero period is the only enable. Writing zero stops the timer, and writing a nonzero value starts it, or restarts it with the new value.

The period moves into the timer domain through a toggle handshake with a held data word, so the timer never sees a half-changed value. Each timer event goes back to the bus domain through a toggle synchronizer and sets a sticky flag. Software clears the flag by writing one to it. The interrupt output is the flag gated by an enable bit. A one-cycle event strobe in the timer domain is also brought out for use by logic in that domain.

Top module: `api_timer`

## Requirements
- R1: After reset, the control register (addr_i = 0) reads as zero, the status register (addr_i = 1) reads as zero, and irq_o and tick_o are low.
- R2: While the period loaded into the timer domain is zero, tick_o never pulses.
- R3: While a nonzero period P is loaded, successive tick_o pulses are exactly P+1 timer-clock cycles apart. Periods below 4 are not supported.
- R4: After a nonzero period P is written while the timer is stopped, the first tick_o pulse comes P+3 to P+6 timer-clock cycles after the write. This allows for synchronization latency.
- R5: When the period is rewritten while running, the counter restarts from zero on the timer cycle that loads the new value. Later pulses use the new spacing, and the transferred value stays stable while a transfer is in flight.
- R6: Writing zero to the period stops tick_o pulses once the value has crossed domains, and the timer count never exceeds the loaded period.
- R7: Each tick_o pulse sets the flag, which reads as bit 0 of the status register.
- R8: Writing the status register with bit 0 = 1 clears the flag. Writing bit 0 = 0 leaves it set. A new event in the same cycle takes priority over the clear.
- R9: irq_o is high exactly when the flag is set and the interrupt-enable bit (control bit 16) is set.
- R10: The control register reads back the period in bits 9:0 and the interrupt enable in bit 16. All other bits read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| tmr_clk_i | input | 1 | Timer clock |
| rst_ni | input | 1 | Asynchronous active-low reset, both domains |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 1 | Register select: 0 control, 1 status |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for the selected register |
| irq_o | output | 1 | Interrupt: flag AND enable |
| tick_o | output | 1 | One-cycle event strobe, timer domain |

## Verification
The assertions check on every cycle that:
- the flag stays set until a one is written to clear it;
- a clear with no event present drops the flag;
- irq_o stays low while the enable is off;
- a zero period gives no strobe;
- the count stays within the loaded period;
- the spacing between strobes equals the loaded period plus one;
- the held transfer word does not move during a handshake.

Only the bench scenarios can show the following:
- first-event latency measured from a bus write;
- that a rewritten period actually reaches the timer;
- that a zero write stops events after crossing;
- register read-back.

The bench covers these with sweeps over periods 4 to 20 and 1023.

// File: rtl/api_timer_pkg.sv
package api_timer_pkg;
  parameter int unsigned DATA_W = 32;
  parameter int unsigned IE_BIT = 16;
  typedef enum logic {
    SEL_CTRL = 1'b0,
    SEL_STAT = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/api_regs.sv
module api_regs
  import api_timer_pkg::*;
#(
  parameter int unsigned PW = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              evt_i,
  output logic [PW-1:0]     period_o,
  output logic              ie_o,
  output logic              flag_o,
  output logic              irq_o
);
  logic [PW-1:0] period_q;
  logic          ie_q;
  logic          flag_q;
  logic          wr_ctrl, w1c;

  assign wr_ctrl = wr_en_i && (reg_sel_e'(addr_i) == SEL_CTRL);
  assign w1c     = wr_en_i && (reg_sel_e'(addr_i) == SEL_STAT) && wdata_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_q <= '0;
      ie_q     <= 1'b0;
    end else if (wr_ctrl) begin
      period_q <= wdata_i[PW-1:0];
      ie_q     <= wdata_i[IE_BIT];
    end
  end

  // event wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= evt_i | (flag_q & ~w1c);
  end

  always_comb begin
    rdata_o = '0;
    if (reg_sel_e'(addr_i) == SEL_CTRL) begin
      rdata_o[PW-1:0] = period_q;
      rdata_o[IE_BIT] = ie_q;
    end else begin
      rdata_o[0] = flag_q;
    end
  end

  assign period_o = period_q;
  assign ie_o     = ie_q;
  assign flag_o   = flag_q;
  assign irq_o    = flag_q & ie_q;
endmodule

// File: rtl/api_cdc_xfer.sv
module api_cdc_xfer #(
  parameter int unsigned W = 10
) (
  input  logic         src_clk_i,
  input  logic         dst_clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] src_data_i,
  output logic         src_busy_o,
  output logic [W-1:0] src_held_o,
  output logic         dst_load_o,
  output logic [W-1:0] dst_data_o
);
  logic         req_q, ack_s1, ack_s2;
  logic [W-1:0] held_q;
  logic         req_s1, req_s2, seen_q;
  logic         busy, launch;

  assign busy   = req_q ^ ack_s2;
  assign launch = !busy && (src_data_i != held_q);

  always_ff @(posedge src_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      held_q <= '0;
      ack_s1 <= 1'b0;
      ack_s2 <= 1'b0;
    end else begin
      ack_s1 <= seen_q;
      ack_s2 <= ack_s1;
      if (launch) begin
        held_q <= src_data_i;
        req_q  <= ~req_q;
      end
    end
  end

  always_ff @(posedge dst_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_s1 <= 1'b0;
      req_s2 <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      req_s1 <= req_q;
      req_s2 <= req_s1;
      seen_q <= req_s2;
    end
  end

  assign dst_load_o = req_s2 ^ seen_q;
  assign dst_data_o = held_q;  // held stable until ack returns
  assign src_busy_o = busy;
  assign src_held_o = held_q;
endmodule

// File: rtl/api_counter.sv
module api_counter #(
  parameter int unsigned W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] period_i,
  output logic         tick_o,
  output logic [W-1:0] period_o,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] per_q, cnt_q;
  logic         tick_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_q  <= '0;
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (load_i) begin
      per_q  <= period_i;
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (per_q != '0) begin
      if (cnt_q == per_q) begin
        cnt_q  <= '0;
        tick_q <= 1'b1;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
        tick_q <= 1'b0;
      end
    end else begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end
  end

  assign tick_o   = tick_q;
  assign period_o = per_q;
  assign cnt_o    = cnt_q;
endmodule

// File: rtl/api_evt_sync.sv
module api_evt_sync (
  input  logic src_clk_i,
  input  logic dst_clk_i,
  input  logic rst_ni,
  input  logic src_pulse_i,
  output logic dst_pulse_o
);
  logic tgl_q;
  logic [2:0] sync_q;

  always_ff @(posedge src_clk_i or negedge rst_ni) begin
    if (!rst_ni)          tgl_q <= 1'b0;
    else if (src_pulse_i) tgl_q <= ~tgl_q;
  end

  always_ff @(posedge dst_clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[1:0], tgl_q};
  end

  assign dst_pulse_o = sync_q[2] ^ sync_q[1];
endmodule

// File: rtl/api_timer.sv
module api_timer
  import api_timer_pkg::*;
#(
  parameter int unsigned PERIOD_W = 10
) (
  input  logic              clk_i,
  input  logic              tmr_clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  output logic              tick_o
);
  logic [PERIOD_W-1:0] period_b, held, per_t, cnt_t, data_t;
  logic                ie, flag, evt_bus, busy, load_t, tick_t;

  api_regs #(.PW(PERIOD_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i, .rdata_o,
    .evt_i(evt_bus), .period_o(period_b), .ie_o(ie), .flag_o(flag), .irq_o
  );

  api_cdc_xfer #(.W(PERIOD_W)) u_xfer (
    .src_clk_i(clk_i), .dst_clk_i(tmr_clk_i), .rst_ni,
    .src_data_i(period_b), .src_busy_o(busy), .src_held_o(held),
    .dst_load_o(load_t), .dst_data_o(data_t)
  );

  api_counter #(.W(PERIOD_W)) u_cnt (
    .clk_i(tmr_clk_i), .rst_ni, .load_i(load_t), .period_i(data_t),
    .tick_o(tick_t), .period_o(per_t), .cnt_o(cnt_t)
  );

  api_evt_sync u_evt (
    .src_clk_i(tmr_clk_i), .dst_clk_i(clk_i), .rst_ni,
    .src_pulse_i(tick_t), .dst_pulse_o(evt_bus)
  );

  assign tick_o = tick_t;
endmodule

// File: rtl/api_timer_chk.sv
module api_timer_chk #(
  parameter int unsigned PW = 10
) (
  input logic          clk_i,
  input logic          tmr_clk_i,
  input logic          rst_ni,
  input logic          wr_en_i,
  input logic          addr_i,
  input logic [31:0]   wdata_i,
  input logic          irq_o,
  input logic          ie,
  input logic          flag,
  input logic          evt_bus,
  input logic          busy,
  input logic [PW-1:0] held,
  input logic          load_t,
  input logic          tick_t,
  input logic [PW-1:0] per_t,
  input logic [PW-1:0] cnt_t
);
  logic        w1c;
  logic [11:0] gap_q;
  logic        armed_q;

  assign w1c = wr_en_i && addr_i && wdata_i[0];

  always_ff @(posedge tmr_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      if (tick_t)              gap_q <= 12'd1;
      else if (gap_q != '1)    gap_q <= gap_q + 1'b1;
      if (load_t)              armed_q <= 1'b0;
      else if (tick_t)         armed_q <= 1'b1;
    end
  end

  // R8
  flag_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag && !w1c |=> flag);
  // R8
  flag_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w1c && !evt_bus |=> !flag);
  // R9
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ie |-> !irq_o);
  // R2
  idle_chk: assert property (@(posedge tmr_clk_i) disable iff (!rst_ni)
    per_t == '0 |=> !tick_t);
  // R6
  cnt_range_chk: assert property (@(posedge tmr_clk_i) disable iff (!rst_ni)
    cnt_t <= per_t);
  // R3
  gap_chk: assert property (@(posedge tmr_clk_i) disable iff (!rst_ni)
    tick_t && armed_q |-> gap_q == 12'(per_t) + 12'd1);
  // R5
  held_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> $stable(held));
endmodule

bind api_timer api_timer_chk #(.PW(PERIOD_W)) u_chk (
  .clk_i(clk_i), .tmr_clk_i(tmr_clk_i), .rst_ni(rst_ni),
  .wr_en_i(wr_en_i), .addr_i(addr_i), .wdata_i(wdata_i), .irq_o(irq_o),
  .ie(ie), .flag(flag), .evt_bus(evt_bus), .busy(busy), .held(held),
  .load_t(load_t), .tick_t(tick_t), .per_t(per_t), .cnt_t(cnt_t)
);

// File: tb/api_timer_test.sv
module api_timer_test;
  localparam int BUS_PERIOD = 10;
  localparam int TMR_PERIOD = 30;

  logic        clk = 1'b0, tmr_clk = 1'b0, rst_n = 1'b0;
  logic        wr_en = 1'b0, addr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq, tick;

  int tests = 0, fails = 0;
  int tcyc = 0, ntick = 0;
  int ticks [0:4095];
  bit done = 1'b0;

  api_timer uut (
    .clk_i(clk), .tmr_clk_i(tmr_clk), .rst_ni(rst_n), .wr_en_i(wr_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .tick_o(tick)
  );

  always #(BUS_PERIOD/2) clk = ~clk;
  always #(TMR_PERIOD/2) tmr_clk = ~tmr_clk;

  always @(posedge tmr_clk) tcyc <= tcyc + 1;
  always @(negedge tmr_clk) if (rst_n && tick) begin
    if (ntick < 4096) ticks[ntick] = tcyc;
    ntick = ntick + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic wait_tmr(input int n);
    repeat (n) @(posedge tmr_clk);
    @(negedge tmr_clk);
  endtask

  initial begin
    #(BUS_PERIOD*200000);
    $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
    fails++; tests++;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int base, w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    bus_rd(1'b0, d); check(d == 0, "R1 ctrl", d, 0);
    bus_rd(1'b1, d); check(d == 0, "R1 stat", d, 0);
    check(irq == 0 && tick == 0, "R1 outputs", {irq, tick}, 0);
    // R2 no ticks with zero period
    base = ntick; wait_tmr(100);
    check(ntick == base, "R2 idle", ntick - base, 0);
    // R10 read-back
    bus_wr(1'b0, 32'hFFFE_0000 | 32'h0003_0000);
    bus_rd(1'b0, d); check(d == 32'h0001_0000, "R10 ie only", d, 32'h0001_0000);
    bus_wr(1'b0, 32'h0000_FC00 | 32'd0); bus_rd(1'b0, d);
    check(d == 0, "R10 upper bits", d, 0);
    // R4 first-event latency
    for (int p = 4; p <= 15; p += 5) begin
      bus_wr(1'b0, 0); wait_tmr(20);
      base = ntick;
      @(negedge clk); w = tcyc;
      wr_en = 1'b1; addr = 1'b0; wdata = p;
      @(negedge clk); wr_en = 1'b0;
      wait_tmr(p + 12);
      check(ntick > base && ticks[base] - w >= p + 3 && ticks[base] - w <= p + 6,
            "R4 first latency", ticks[base] - w, p + 4);
    end
    // R3/R5 sweep with running rewrites
    for (int p = 4; p <= 20; p++) begin
      bit ok = 1'b1; int bad = 0;
      bus_wr(1'b0, p); wait_tmr(14);
      base = ntick; wait_tmr((p + 1) * 4 + 2);
      if (ntick - base < 3) begin ok = 1'b0; bad = ntick - base; end
      for (int i = base + 1; i < ntick; i++)
        if (ticks[i] - ticks[i-1] != p + 1) begin ok = 1'b0; bad = ticks[i] - ticks[i-1]; end
      check(ok, "R3 R5 interval", bad, p + 1);
    end
    begin
      bit ok = 1'b1; int bad = 0;
      bus_wr(1'b0, 1023); wait_tmr(14);
      base = ntick; wait_tmr(1024 * 3 + 4);
      if (ntick - base < 3) ok = 1'b0;
      for (int i = base + 1; i < ntick; i++)
        if (ticks[i] - ticks[i-1] != 1024) begin ok = 1'b0; bad = ticks[i] - ticks[i-1]; end
      check(ok, "R3 max period", bad, 1024);
    end
    // R7 flag set by events
    bus_wr(1'b0, 5); wait_tmr(20);
    bus_rd(1'b1, d); check(d == 1, "R7 flag", d, 1);
    check(irq == 0, "R9 ie off", irq, 0);
    bus_wr(1'b0, 32'h0001_0005); #1;
    check(irq == 1, "R9 ie on", irq, 1);
    // R6 stop
    bus_wr(1'b0, 32'h0001_0000); wait_tmr(10);
    base = ntick; wait_tmr(200);
    check(ntick == base, "R6 stopped", ntick - base, 0);
    // R8 clear behaviour
    bus_wr(1'b1, 32'h0000_0000); bus_rd(1'b1, d);
    check(d == 1, "R8 write zero keeps", d, 1);
    bus_wr(1'b1, 32'h0000_0001); bus_rd(1'b1, d);
    check(d == 0, "R8 w1c", d, 0);
    check(irq == 0, "R9 irq low after clear", irq, 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule